// File: doc/BRIEF.md
# Flash Write Status Reporter

This block sits on the read path of a NOR-style flash device. While an embedded program or erase runs, it replaces one bit of every array read with a polling flag. It also drives an open-drain ready/busy line, modelled as an active-high pull-down enable. The command decoder raises a single-cycle pulse when a program, chip-erase or sector-erase sequence completes its last write cycle. The pulse comes with a flag that says whether the target sector is locked and, for a program, the word being written. A device-level reset request and an erase suspend/resume request arrive as single-cycle pulses.

Each embedded operation is a down-counter whose length in clock cycles is a parameter. There are six lengths: normal program, normal erase, program on a locked sector, erase on a locked sector, and the long and short internal reset. While an operation runs, reads still return array data on every bit except the flag bit (parameter `SB`, bit 7 by default). Once the block is back in read mode, reads pass the array word unchanged.

Top module: `fsr_top`

## Requirements
- R1: After `rst_n` the block is in read mode: `busy_pull_en`=0, `rd_valid`=0, `rd_word`=0. In read mode a `rd_strobe` sampled on one edge makes `rd_word` equal `array_word` and `rd_valid`=1 in the following cycle only.
- R2: A `prog_done_pulse` accepted in read mode with `sector_locked`=0 asserts `busy_pull_en` from the next cycle for exactly `T_PROG` cycles. Reads sampled in those cycles return `array_word` with bit `SB` replaced by the complement of bit `SB` of the `prog_word` captured with the pulse.
- R3: A `chip_erase_pulse` or `sector_erase_pulse` accepted in read mode with `sector_locked`=0 asserts `busy_pull_en` for exactly `T_ERASE` cycles. Reads during that time return `array_word` with bit `SB` forced to 0.
- R4: When an operation's count expires, the block returns to read mode and reads pass `array_word` unchanged (an erased all-ones word reads as all ones).
- R5: A program accepted with `sector_locked`=1 gives a short false-busy episode of `T_PPROT` cycles, with the same bit `SB` status as R2, and then returns to read mode.
- R6: An erase accepted with `sector_locked`=1 gives busy and erase status (bit `SB`=0) for `T_EPROT` cycles, then returns to read mode.
- R7: While busy or suspended, program and erase pulses are ignored: the running operation's duration and status bit are unchanged. `suspend_req` has no effect outside an unlocked erase.
- R8: `suspend_req` during an unlocked erase releases `busy_pull_en` from the next cycle and freezes the erase count. Suspended reads return bit `SB`=1. A second `suspend_req` resumes the erase. Total busy cycles of a suspended erase are `T_ERASE` plus one per suspension.
- R9: A `reset_req` while an operation runs or is suspended asserts `busy_pull_en` from the next cycle for exactly `T_RSTL` cycles. Reads return all zeros during that time.
- R10: A `reset_req` in read mode starts a short reset of `T_RSTS` cycles. During it `busy_pull_en` stays 0, reads return all zeros, and commands are ignored.
- R11: Priority: `reset_req` wins over any command in the same cycle. Among simultaneous commands, program wins over chip erase, and chip erase wins over sector erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the logic |
| prog_done_pulse | input | 1 | Last write cycle of a program sequence |
| chip_erase_pulse | input | 1 | Last write cycle of a chip-erase sequence |
| sector_erase_pulse | input | 1 | Last write cycle of a sector-erase sequence |
| sector_locked | input | 1 | Target sector is write-protected, sampled with a command |
| suspend_req | input | 1 | Erase suspend/resume request pulse |
| reset_req | input | 1 | Device reset request pulse |
| prog_word | input | DW | Word being programmed, sampled with `prog_done_pulse` |
| rd_strobe | input | 1 | Read request |
| array_word | input | DW | Array data for the read |
| rd_word | output | DW | Read data, one cycle after the strobe |
| rd_valid | output | 1 | `rd_word` holds a new read |
| busy_pull_en | output | 1 | Pull the open-drain ready line low |

## Verification
The hardest condition to reach is an erase that has been suspended and then resumed. A correct total busy count depends on the frozen counter picking up exactly where it stopped. The stimulus starts an unlocked sector erase and suspends it after three cycles. It then reads the suspended status and injects a program pulse that must be ignored. After that it resumes and counts busy cycles until release, expecting `T_ERASE`+1. A second hard case is a long reset entered from the suspended state, where busy must come back even though the line was released.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PROG  = 3'd1,
        ST_PPROT = 3'd2,
        ST_ERASE = 3'd3,
        ST_EPROT = 3'd4,
        ST_SUSP  = 3'd5,
        ST_RSTL  = 3'd6,
        ST_RSTS  = 3'd7
    } fsr_state_e;

    typedef enum logic [2:0] {
        RD_PASS  = 3'd0,
        RD_PROG  = 3'd1,
        RD_ERASE = 3'd2,
        RD_SUSP  = 3'd3,
        RD_BLANK = 3'd4
    } fsr_rdmode_e;

    function automatic int unsigned fsr_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fsr_timer.sv
module fsr_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    output logic          zero
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
    import fsr_pkg::*;
#(
    parameter int unsigned DW      = 16,
    parameter int unsigned SB      = 7,
    parameter int unsigned CW      = 8,
    parameter int unsigned T_PROG  = 40,
    parameter int unsigned T_ERASE = 200,
    parameter int unsigned T_PPROT = 125,
    parameter int unsigned T_EPROT = 18750,
    parameter int unsigned T_RSTL  = 60,
    parameter int unsigned T_RSTS  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_go,
    input  logic          cerase_go,
    input  logic          serase_go,
    input  logic          locked,
    input  logic          susp_req,
    input  logic          rst_req,
    input  logic [DW-1:0] prog_word,
    input  logic          tmr_zero,
    output fsr_state_e    st,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          tmr_run,
    output logic          busy,
    output fsr_rdmode_e   rd_mode,
    output logic          stat_bit
);

    localparam logic [CW-1:0] LV_PROG  = CW'(T_PROG  - 1);
    localparam logic [CW-1:0] LV_ERASE = CW'(T_ERASE - 1);
    localparam logic [CW-1:0] LV_PPROT = CW'(T_PPROT - 1);
    localparam logic [CW-1:0] LV_EPROT = CW'(T_EPROT - 1);
    localparam logic [CW-1:0] LV_RSTL  = CW'(T_RSTL  - 1);
    localparam logic [CW-1:0] LV_RSTS  = CW'(T_RSTS  - 1);

    typedef struct packed {
        fsr_state_e st;
        logic       inv;
    } ctrl_t;

    ctrl_t cur_q, nxt_d;
    logic  in_reset;
    logic  any_erase;

    assign in_reset  = (cur_q.st == ST_RSTL) || (cur_q.st == ST_RSTS);
    assign any_erase = cerase_go || serase_go;

    always_comb begin
        nxt_d    = cur_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        tmr_run  = 1'b0;
        if (rst_req && !in_reset) begin
            // reset wins over every command
            tmr_load = 1'b1;
            if (cur_q.st == ST_IDLE) begin
                nxt_d.st = ST_RSTS;
                tmr_val  = LV_RSTS;
            end else begin
                nxt_d.st = ST_RSTL;
                tmr_val  = LV_RSTL;
            end
        end else begin
            unique case (cur_q.st)
                ST_IDLE: begin
                    if (prog_go) begin
                        tmr_load  = 1'b1;
                        nxt_d.inv = ~prog_word[SB];
                        if (locked) begin
                            nxt_d.st = ST_PPROT;
                            tmr_val  = LV_PPROT;
                        end else begin
                            nxt_d.st = ST_PROG;
                            tmr_val  = LV_PROG;
                        end
                    end else if (any_erase) begin
                        tmr_load = 1'b1;
                        if (locked) begin
                            nxt_d.st = ST_EPROT;
                            tmr_val  = LV_EPROT;
                        end else begin
                            nxt_d.st = ST_ERASE;
                            tmr_val  = LV_ERASE;
                        end
                    end
                end
                ST_ERASE: begin
                    if (susp_req) begin
                        nxt_d.st = ST_SUSP;
                    end else begin
                        tmr_run = 1'b1;
                        if (tmr_zero) begin
                            nxt_d.st = ST_IDLE;
                        end
                    end
                end
                ST_SUSP: begin
                    if (susp_req) begin
                        nxt_d.st = ST_ERASE;
                    end
                end
                default: begin
                    tmr_run = 1'b1;
                    if (tmr_zero) begin
                        nxt_d.st = ST_IDLE;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_IDLE, inv: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        busy    = 1'b0;
        rd_mode = RD_PASS;
        unique case (cur_q.st)
            ST_PROG, ST_PPROT: begin
                busy    = 1'b1;
                rd_mode = RD_PROG;
            end
            ST_ERASE, ST_EPROT: begin
                busy    = 1'b1;
                rd_mode = RD_ERASE;
            end
            ST_SUSP: rd_mode = RD_SUSP;
            ST_RSTL: begin
                busy    = 1'b1;
                rd_mode = RD_BLANK;
            end
            ST_RSTS: rd_mode = RD_BLANK;
            default: rd_mode = RD_PASS;
        endcase
    end

    assign st       = cur_q.st;
    assign stat_bit = cur_q.inv;

endmodule

// File: rtl/fsr_rdpath.sv
module fsr_rdpath
    import fsr_pkg::*;
#(
    parameter int unsigned DW = 16,
    parameter int unsigned SB = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_strobe,
    input  logic [DW-1:0] array_word,
    input  fsr_rdmode_e   rd_mode,
    input  logic          stat_bit,
    output logic [DW-1:0] rd_word,
    output logic          rd_valid
);

    typedef struct packed {
        logic [DW-1:0] data;
        logic          valid;
    } rd_t;

    rd_t rd_q, rd_d;

    always_comb begin
        rd_d       = rd_q;
        rd_d.valid = rd_strobe;
        if (rd_strobe) begin
            rd_d.data = array_word;
            unique case (rd_mode)
                RD_PROG:  rd_d.data[SB] = stat_bit;
                RD_ERASE: rd_d.data[SB] = 1'b0;
                RD_SUSP:  rd_d.data[SB] = 1'b1;
                RD_BLANK: rd_d.data     = '0;
                default:  rd_d.data     = array_word;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_word  = rd_q.data;
    assign rd_valid = rd_q.valid;

endmodule

// File: rtl/fsr_top.sv
module fsr_top
    import fsr_pkg::*;
#(
    parameter int unsigned DW      = 16,
    parameter int unsigned SB      = 7,
    parameter int unsigned T_PROG  = 40,
    parameter int unsigned T_ERASE = 200,
    parameter int unsigned T_PPROT = 125,
    parameter int unsigned T_EPROT = 18750,
    parameter int unsigned T_RSTL  = 60,
    parameter int unsigned T_RSTS  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_done_pulse,
    input  logic          chip_erase_pulse,
    input  logic          sector_erase_pulse,
    input  logic          sector_locked,
    input  logic          suspend_req,
    input  logic          reset_req,
    input  logic [DW-1:0] prog_word,
    input  logic          rd_strobe,
    input  logic [DW-1:0] array_word,
    output logic [DW-1:0] rd_word,
    output logic          rd_valid,
    output logic          busy_pull_en
);

    localparam int unsigned T_MAX = fsr_max(fsr_max(fsr_max(T_PROG, T_ERASE),
                                                    fsr_max(T_PPROT, T_EPROT)),
                                            fsr_max(T_RSTL, T_RSTS));
    localparam int unsigned CW = $clog2(T_MAX + 1);

    fsr_state_e    st_w;
    fsr_rdmode_e   mode_w;
    logic          load_w;
    logic [CW-1:0] lval_w;
    logic          run_w;
    logic          zero_w;
    logic          sbit_w;

    fsr_ctrl #(
        .DW(DW), .SB(SB), .CW(CW),
        .T_PROG(T_PROG), .T_ERASE(T_ERASE), .T_PPROT(T_PPROT),
        .T_EPROT(T_EPROT), .T_RSTL(T_RSTL), .T_RSTS(T_RSTS)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .prog_go  (prog_done_pulse),
        .cerase_go(chip_erase_pulse),
        .serase_go(sector_erase_pulse),
        .locked   (sector_locked),
        .susp_req (suspend_req),
        .rst_req  (reset_req),
        .prog_word(prog_word),
        .tmr_zero (zero_w),
        .st       (st_w),
        .tmr_load (load_w),
        .tmr_val  (lval_w),
        .tmr_run  (run_w),
        .busy     (busy_pull_en),
        .rd_mode  (mode_w),
        .stat_bit (sbit_w)
    );

    fsr_timer #(.CW(CW)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_w),
        .load_val(lval_w),
        .run     (run_w),
        .zero    (zero_w)
    );

    fsr_rdpath #(.DW(DW), .SB(SB)) rdpath_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_strobe (rd_strobe),
        .array_word(array_word),
        .rd_mode   (mode_w),
        .stat_bit  (sbit_w),
        .rd_word   (rd_word),
        .rd_valid  (rd_valid)
    );

endmodule

// File: rtl/fsr_checker.sv
module fsr_checker
    import fsr_pkg::*;
#(
    parameter int unsigned DW = 16,
    parameter int unsigned SB = 7
) (
    input logic          clk,
    input logic          rst_n,
    input fsr_state_e    st,
    input logic          prog_done_pulse,
    input logic          sector_locked,
    input logic          suspend_req,
    input logic          reset_req,
    input logic          rd_strobe,
    input logic [DW-1:0] rd_word,
    input logic          rd_valid,
    input logic          busy_pull_en
);

    assert_rd_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> rd_valid);

    assert_rd_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> !rd_valid);

    assert_prog_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !reset_req && prog_done_pulse && !sector_locked) |=> busy_pull_en);

    assert_erase_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && st == ST_ERASE) |=> (rd_word[SB] == 1'b0));

    assert_prog_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROG && !reset_req) |=> (st == ST_PROG || st == ST_IDLE));

    assert_susp_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERASE && suspend_req && !reset_req) |=> (!busy_pull_en && st == ST_SUSP));

    assert_long_rst_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req && st != ST_IDLE && st != ST_RSTL && st != ST_RSTS) |=> busy_pull_en);

    assert_rst_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && (st == ST_RSTL || st == ST_RSTS)) |=> (rd_word == '0));

    assert_short_rst_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && reset_req) |=> !busy_pull_en);

endmodule

bind fsr_top fsr_checker #(.DW(DW), .SB(SB)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .st             (st_w),
    .prog_done_pulse(prog_done_pulse),
    .sector_locked  (sector_locked),
    .suspend_req    (suspend_req),
    .reset_req      (reset_req),
    .rd_strobe      (rd_strobe),
    .rd_word        (rd_word),
    .rd_valid       (rd_valid),
    .busy_pull_en   (busy_pull_en)
);

// File: tb/fsr_top_tb_top.sv
module fsr_top_tb_top;

    localparam int TP  = 5;
    localparam int TE  = 9;
    localparam int TPP = 3;
    localparam int TEP = 4;
    localparam int TRL = 6;
    localparam int TRS = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_go = 1'b0, cer_go = 1'b0, ser_go = 1'b0;
    logic        locked = 1'b0, susp = 1'b0, rreq = 1'b0;
    logic [15:0] pword = '0;
    logic        rd_en = 1'b0;
    logic [15:0] arr = '0;
    logic [15:0] rd_word;
    logic        rd_ok;
    logic        pull_en;
    logic        ready_line;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    assign ready_line = ~pull_en;

    fsr_top #(
        .DW(16), .SB(7), .T_PROG(TP), .T_ERASE(TE), .T_PPROT(TPP),
        .T_EPROT(TEP), .T_RSTL(TRL), .T_RSTS(TRS)
    ) dut_i (
        .clk               (clk),
        .rst_n             (rst_n),
        .prog_done_pulse   (prog_go),
        .chip_erase_pulse  (cer_go),
        .sector_erase_pulse(ser_go),
        .sector_locked     (locked),
        .suspend_req       (susp),
        .reset_req         (rreq),
        .prog_word         (pword),
        .rd_strobe         (rd_en),
        .array_word        (arr),
        .rd_word           (rd_word),
        .rd_valid          (rd_ok),
        .busy_pull_en      (pull_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic count_busy(input int n, output int c);
        c = 0;
        for (int k = 0; k < n; k++) begin
            if (pull_en) c++;
            @(negedge clk);
        end
    endtask

    function automatic logic [15:0] pattern(input int i, input int salt);
        logic [7:0] hi, lo;
        hi = 8'(i * 37 + salt);
        lo = 8'(i * 53 + salt * 11);
        return {hi, lo};
    endfunction

    // kind: 0 program, 1 chip erase, 2 sector erase
    task automatic run_op(input int kind, input bit p, input logic [15:0] word, input bit noise);
        int          t;
        string       tag;
        logic [15:0] prev_arr;
        logic [15:0] expv;
        bit          prev_rd;
        t = (kind == 0) ? (p ? TPP : TP) : (p ? TEP : TE);
        if (noise) tag = "R7";
        else if (kind == 0) tag = p ? "R5" : "R2";
        else tag = p ? "R6" : "R3";
        prog_go = (kind == 0);
        cer_go  = (kind == 1);
        ser_go  = (kind == 2);
        locked  = p;
        pword   = word;
        rd_en   = 1'b0;
        prev_rd = 1'b0;
        prev_arr = '0;
        @(negedge clk);
        prog_go = 1'b0; cer_go = 1'b0; ser_go = 1'b0;
        for (int i = 1; i <= t + 3; i++) begin
            chk((i <= t) ? tag : "R4", {31'd0, pull_en}, {31'd0, (i <= t)});
            if (prev_rd) begin
                expv = prev_arr;
                if (i - 1 <= t) expv[7] = (kind == 0) ? ~word[7] : 1'b0;
                chk((i - 1 <= t) ? tag : "R4", {16'd0, rd_word}, {16'd0, expv});
                chk("R1", {31'd0, rd_ok}, 32'd1);
            end
            prog_go = 1'b0; cer_go = 1'b0; ser_go = 1'b0; susp = 1'b0;
            if (noise && i == 2) begin
                prog_go = 1'b1;
                pword   = ~word;
                cer_go  = 1'b1;
                ser_go  = 1'b1;
                susp    = (kind == 0) || p;
            end
            arr      = (i == t + 2) ? 16'hFFFF : pattern(i, kind * 4 + int'(p) * 2 + int'(word[7]));
            rd_en    = (i < t + 3);
            prev_rd  = rd_en;
            prev_arr = arr;
            @(negedge clk);
        end
        rd_en  = 1'b0;
        locked = 1'b0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        int c;
        repeat (3) @(negedge clk);
        chk("R1", {31'd0, pull_en}, 32'd0);
        chk("R1", {31'd0, rd_ok}, 32'd0);
        chk("R1", {16'd0, rd_word}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {31'd0, pull_en}, 32'd0);

        // read mode passthrough
        rd_en = 1'b1; arr = 16'hBEEF;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R1", {16'd0, rd_word}, 32'h0000BEEF);
        chk("R1", {31'd0, rd_ok}, 32'd1);
        @(negedge clk);
        chk("R1", {31'd0, rd_ok}, 32'd0);

        // sweep: command kind x lock x data bit x noise
        for (int k = 0; k < 3; k++)
            for (int p = 0; p < 2; p++)
                for (int b = 0; b < 2; b++)
                    for (int n = 0; n < 2; n++)
                        run_op(k, p[0], b[0] ? 16'h00A5 : 16'h1322, n[0]);

        // R8: suspend and resume an unlocked erase
        ser_go = 1'b1;
        @(negedge clk);
        ser_go = 1'b0;
        c = 0;
        for (int j = 1; j <= 3; j++) begin
            if (pull_en) c++;
            susp = (j == 3);
            @(negedge clk);
        end
        susp = 1'b0;
        chk("R8", {31'd0, pull_en}, 32'd0);
        rd_en = 1'b1; arr = 16'h0000;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R8", {16'd0, rd_word}, 32'h00000080);
        chk("R8", {31'd0, pull_en}, 32'd0);
        prog_go = 1'b1; pword = 16'h0000;
        @(negedge clk);
        prog_go = 1'b0;
        chk("R7", {31'd0, pull_en}, 32'd0);
        susp = 1'b1;
        @(negedge clk);
        susp = 1'b0;
        begin
            int c2;
            count_busy(TE + 6, c2);
            chk("R8", c + c2, TE + 1);
        end
        rd_en = 1'b1; arr = 16'h0001;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R7", {16'd0, rd_word}, 32'h00000001);

        // R9: reset during a program
        prog_go = 1'b1; pword = 16'h0000;
        @(negedge clk);
        prog_go = 1'b0;
        c = 0;
        if (pull_en) c++;
        @(negedge clk);
        if (pull_en) c++;
        rreq = 1'b1;
        @(negedge clk);
        rreq = 1'b0;
        if (pull_en) c++;
        rd_en = 1'b1; arr = 16'h5555;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R9", {16'd0, rd_word}, 32'd0);
        begin
            int c2;
            count_busy(TRL + 5, c2);
            chk("R9", c + c2, 2 + TRL);
        end

        // R9: reset from the suspended state
        ser_go = 1'b1;
        @(negedge clk);
        ser_go = 1'b0; susp = 1'b1;
        @(negedge clk);
        susp = 1'b0;
        chk("R8", {31'd0, pull_en}, 32'd0);
        rreq = 1'b1;
        @(negedge clk);
        rreq = 1'b0;
        chk("R9", {31'd0, pull_en}, 32'd1);
        count_busy(TRL + 5, c);
        chk("R9", c, TRL);

        // R10: short reset in read mode
        rreq = 1'b1;
        @(negedge clk);
        rreq = 1'b0;
        chk("R10", {31'd0, pull_en}, 32'd0);
        rd_en = 1'b1; arr = 16'h1234; prog_go = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; prog_go = 1'b0;
        chk("R10", {16'd0, rd_word}, 32'd0);
        count_busy(TP + 6, c);
        chk("R10", c, 0);
        rd_en = 1'b1; arr = 16'h1234;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R10", {16'd0, rd_word}, 32'h00001234);

        // R11: reset beats program in the same cycle
        rreq = 1'b1; prog_go = 1'b1;
        @(negedge clk);
        rreq = 1'b0; prog_go = 1'b0;
        count_busy(TP + 6, c);
        chk("R11", c, 0);

        // R11: program beats chip erase in the same cycle
        prog_go = 1'b1; cer_go = 1'b1; pword = 16'h0000;
        @(negedge clk);
        prog_go = 1'b0; cer_go = 1'b0;
        c = pull_en ? 1 : 0;
        rd_en = 1'b1; arr = 16'h0000;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R11", {16'd0, rd_word}, 32'h00000080);
        begin
            int c2;
            count_busy(TE + 6, c2);
            chk("R11", c + c2, TP);
        end
        chk("R11", {31'd0, ready_line}, 32'd1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule